// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel. It advances only on cycles where the tick enable is high, so the tick enable sets the timer rate while the logic runs on the system clock. A separate register block decodes host accesses, assembles the bytes of a new count, and presents that count with a mode field on a one-cycle load strobe. This channel then produces the output waveform for the selected mode. It also keeps the current count on a live output so that the register block can latch it.

There are six output behaviours:

- a level that rises at terminal count;
- a gate-retriggered one-shot;
- a periodic single-tick rate pulse;
- a square wave;
- a strobe started by software;
- a strobe started by the gate.

The gate input either pauses counting or, on a rising edge, restarts the current period from the loaded value, depending on the mode. A loaded value of zero stands for the largest count, 65536.

Top module: `ictr_channel`

## Requirements
- R1: After reset the channel is in mode 3 with a count of 65536. The output `count_o` reads 0 and `out_o` is high.
- R2: A load value of 0 is taken as 65536. Right after such a load `count_o` reads 0, and one counting tick later it reads 65535.
- R3: In mode 0, `out_o` is low from the load until the number of counting ticks since the load (d) reaches the count N. From then on it stays high until the next load.
- R4: In mode 1, `out_o` is low while d < N and high once d >= N.
- R5: In mode 2, the counter reloads every N ticks. `out_o` is high for exactly the one tick where d is a nonzero multiple of N. `count_o` shows N - (d mod N), and 65536 reads as 0.
- R6: In mode 3, `out_o` is high while (d mod N) < ceil(N/2) and low otherwise, so the high half is the longer one for odd N. `count_o` shows N - (d mod N).
- R7: In modes 4 and 5, `out_o` is high only while d == N, and does not pulse again until the next load or restart. In modes 0, 1, 4 and 5, `count_o` shows (N - d) mod 65536.
- R8: A mode field of 6 behaves as mode 2, and a mode field of 7 behaves as mode 3.
- R9: In modes 0, 2, 3 and 4, a counting tick taken while `gate` is low is ignored, and the count is held. In modes 1 and 5 the gate level does not affect counting.
- R10: A rising edge on `gate` (low in the previous clock, high in this one) sets d back to 0 in modes 1, 2, 3 and 5. It has no effect in modes 0 and 4.
- R11: The count changes only on a cycle with `tick` high, a load, or a restart. On any other cycle `count_o` and `out_o` hold.
- R12: A load takes priority over a gate restart and over a tick in the same cycle: the cycle leaves d = 0 with the newly loaded N and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick enable; one counting step per high cycle |
| gate | input | 1 | Gate level; also sampled for rising edges |
| load_stb | input | 1 | One-cycle strobe that loads a new mode and count |
| load_mode | input | 3 | Mode field captured on the load strobe |
| load_val | input | 16 | Count captured on the load strobe; 0 means 65536 |
| count_o | output | 16 | Live counter value |
| out_o | output | 1 | Channel output waveform |

## Verification
The hardest state to reach is the one-shot strobe that follows a count of zero. The single-tick pulse appears only after 65536 counting ticks, and the bench must then show that no second pulse follows. To get there, the bench loads zero in mode 4, keeps the tick enable high for the whole span, and compares every clock against a model that counts elapsed ticks as a plain integer. Gate edges are placed in the same cycle as loads and ticks, and also while the gate is held low, so that the priority of load over restart and the difference between pausing and retriggering are both exercised.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

    localparam int CNT_W_DEF = 16;

    typedef enum logic [2:0] {
        MODE_TERM     = 3'd0,
        MODE_ONESHOT  = 3'd1,
        MODE_RATE     = 3'd2,
        MODE_SQUARE   = 3'd3,
        MODE_SWSTROBE = 3'd4,
        MODE_HWSTROBE = 3'd5
    } op_mode_e;

    typedef struct packed {
        logic reached;
        logic past;
        logic wrapped;
    } run_flags_t;

    function automatic op_mode_e fold_mode(input logic [2:0] field);
        if (field[2:1] == 2'b11)
            return op_mode_e'({2'b01, field[0]});
        return op_mode_e'(field);
    endfunction

    function automatic logic is_periodic(input op_mode_e m);
        return (m == MODE_RATE) || (m == MODE_SQUARE);
    endfunction

    function automatic logic ignores_gate_level(input op_mode_e m);
        return (m == MODE_ONESHOT) || (m == MODE_HWSTROBE);
    endfunction

    function automatic logic edge_retriggers(input op_mode_e m);
        return (m != MODE_TERM) && (m != MODE_SWSTROBE);
    endfunction

endpackage

// File: rtl/ictr_cfg.sv
module ictr_cfg
    import ictr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_stb,
    input  logic [2:0]       load_mode,
    input  logic [CNT_W-1:0] load_val,
    output op_mode_e         mode,
    output logic [CNT_W:0]   period,
    output logic [CNT_W:0]   ld_period
);
    localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

    always_comb begin
        if (load_val == '0)
            ld_period = FULL;
        else
            ld_period = {1'b0, load_val};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MODE_SQUARE;
            period <= FULL;
        end else if (load_stb) begin
            mode   <= fold_mode(load_mode);
            period <= ld_period;
        end
    end
endmodule

// File: rtl/ictr_gate.sv
module ictr_gate
    import ictr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     gate,
    input  logic     load_stb,
    input  op_mode_e mode,
    output logic     restart,
    output logic     cnt_en
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst)
            gate_q <= 1'b0;
        else
            gate_q <= gate;
    end

    always_comb begin
        restart = gate && !gate_q && edge_retriggers(mode) && !load_stb;
        cnt_en  = tick && (gate || ignores_gate_level(mode));
    end
endmodule

// File: rtl/ictr_core.sv
module ictr_core
    import ictr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_stb,
    input  logic           restart,
    input  logic           cnt_en,
    input  op_mode_e       mode,
    input  logic [CNT_W:0] period,
    input  logic [CNT_W:0] ld_period,
    output logic [CNT_W:0] cnt,
    output run_flags_t     flags
);
    localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] ONE  = {{CNT_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= FULL;
            flags <= '0;
        end else if (load_stb) begin
            cnt   <= ld_period;
            flags <= '0;
        end else if (restart) begin
            cnt   <= period;
            flags <= '0;
        end else if (cnt_en) begin
            if (is_periodic(mode)) begin
                if (cnt == ONE) begin
                    cnt           <= period;
                    flags.wrapped <= 1'b1;
                end else begin
                    cnt <= cnt - ONE;
                end
            end else begin
                cnt <= cnt - ONE;
                if (flags.reached)
                    flags.past <= 1'b1;
                if (cnt == ONE)
                    flags.reached <= 1'b1;
            end
        end
    end

    // R11: no tick, load or restart means the count holds
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_stb && !restart && !cnt_en) |=> $stable(cnt));

    // R2: a zero load leaves the full count
    a_r2_zero_load: assert property (@(posedge clk) disable iff (rst)
        (load_stb && ld_period == FULL) |=> (cnt == FULL));

    // R7: once past terminal count a one-shot stays past until reloaded
    a_r7_past_sticky: assert property (@(posedge clk) disable iff (rst)
        (!is_periodic(mode) && flags.past && !load_stb && !restart) |=> flags.past);

    // R5: a periodic count stays inside 1..period
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst)
        is_periodic(mode) |-> (cnt >= ONE && cnt <= period));
endmodule

// File: rtl/ictr_wave.sv
module ictr_wave
    import ictr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             reload,
    input  op_mode_e         mode,
    input  logic [CNT_W:0]   period,
    input  logic [CNT_W:0]   cnt,
    input  run_flags_t       flags,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);
    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W:0] half;
    logic [CNT_W:0] phase;

    always_comb begin
        half    = (period + ONE) >> 1;
        phase   = period - cnt;
        count_o = cnt[CNT_W-1:0];
        unique case (mode)
            MODE_TERM, MODE_ONESHOT:       out_o = flags.reached;
            MODE_SWSTROBE, MODE_HWSTROBE:  out_o = flags.reached && !flags.past;
            MODE_RATE:                     out_o = flags.wrapped && (cnt == period);
            MODE_SQUARE:                   out_o = phase < half;
            default:                       out_o = 1'b0;
        endcase
    end

    // R5: the rate pulse lasts one counting tick when the period exceeds one
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RATE && out_o && period > ONE && cnt_en && !reload) |=> !out_o);
endmodule

// File: rtl/ictr_channel.sv
module ictr_channel
    import ictr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             gate,
    input  logic             load_stb,
    input  logic [2:0]       load_mode,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);
    op_mode_e       mode;
    logic [CNT_W:0] period;
    logic [CNT_W:0] ld_period;
    logic [CNT_W:0] cnt;
    run_flags_t     flags;
    logic           restart;
    logic           cnt_en;

    ictr_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst(rst), .load_stb(load_stb), .load_mode(load_mode),
        .load_val(load_val), .mode(mode), .period(period), .ld_period(ld_period)
    );

    ictr_gate u_gate (
        .clk(clk), .rst(rst), .tick(tick), .gate(gate), .load_stb(load_stb),
        .mode(mode), .restart(restart), .cnt_en(cnt_en)
    );

    ictr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .load_stb(load_stb), .restart(restart),
        .cnt_en(cnt_en), .mode(mode), .period(period), .ld_period(ld_period),
        .cnt(cnt), .flags(flags)
    );

    ictr_wave #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .reload(load_stb || restart),
        .mode(mode), .period(period), .cnt(cnt), .flags(flags),
        .count_o(count_o), .out_o(out_o)
    );

    // R12: a load wins over a same-cycle gate restart
    a_r12_load_first: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> !restart);
endmodule

// File: tb/ictr_channel_tb.sv
module ictr_channel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        gate = 1'b1;
    logic        load_stb = 1'b0;
    logic [2:0]  load_mode = 3'd0;
    logic [15:0] load_val = 16'd0;
    logic [15:0] count_o;
    logic        out_o;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // behavioural model: elapsed ticks since load/restart
    int m_mode = 3;
    int m_n = 65536;
    longint m_d = 0;
    bit m_gprev = 1'b0;

    always #2 clk = ~clk;

    ictr_channel u_dut (
        .clk(clk), .rst(rst), .tick(tick), .gate(gate), .load_stb(load_stb),
        .load_mode(load_mode), .load_val(load_val), .count_o(count_o), .out_o(out_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 3; m_n = 65536; m_d = 0; m_gprev = 1'b0;
        end else begin
            if (load_stb) begin
                m_n = (load_val == 16'd0) ? 65536 : int'(load_val);
                m_mode = (load_mode >= 3'd6) ? int'(load_mode) - 4 : int'(load_mode);
                m_d = 0;
            end else if (gate && !m_gprev && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
                m_d = 0;
            end else if (tick && (gate || m_mode == 1 || m_mode == 5)) begin
                m_d = m_d + 1;
            end
            m_gprev = gate;
        end
    end

    function automatic bit exp_out();
        longint p = m_d % m_n;
        case (m_mode)
            0, 1:    return m_d >= m_n;
            4, 5:    return m_d == m_n;
            2:       return (p == 0) && (m_d != 0);
            default: return p < ((m_n + 1) / 2);
        endcase
    endfunction

    function automatic int exp_count();
        longint v;
        if (m_mode == 2 || m_mode == 3)
            v = m_n - (m_d % m_n);
        else
            v = m_n - m_d;
        return int'(((v % 65536) + 65536) % 65536);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(count_o == 16'(exp_count()), cur_req, int'(count_o), exp_count());
            check(out_o == exp_out(), cur_req, int'(out_o), int'(exp_out()));
        end
    end

    task automatic do_load(input int md, input int val);
        @(negedge clk);
        load_stb = 1'b1; load_mode = 3'(md); load_val = 16'(val);
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic run(input int n, input int div);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = ((i % div) == 0);
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_gate(input bit g);
        @(negedge clk);
        gate = g;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(count_o == 16'd0, "R1", int'(count_o), 0);
        check(out_o == 1'b1, "R1", int'(out_o), 1);
        cur_req = "R1"; run(8, 1);

        cur_req = "R3"; do_load(0, 5); run(4, 1);
        cur_req = "R9"; set_gate(0); run(4, 1);
        cur_req = "R10"; set_gate(1); run(6, 1);

        cur_req = "R4"; do_load(1, 4); run(7, 1);
        cur_req = "R10"; set_gate(0); run(2, 1); set_gate(1); run(6, 1);
        cur_req = "R9"; set_gate(0); run(3, 1); set_gate(1);

        cur_req = "R5"; do_load(2, 3); run(14, 1); run(9, 3);
        cur_req = "R10"; set_gate(0); run(3, 1); set_gate(1); run(7, 1);

        cur_req = "R6"; do_load(3, 5); run(16, 1);
        do_load(3, 6); run(14, 2);
        cur_req = "R9"; set_gate(0); run(4, 1); set_gate(1); run(4, 1);

        cur_req = "R7"; do_load(4, 3); run(8, 1);
        cur_req = "R9"; do_load(4, 4); set_gate(0); run(3, 1); set_gate(1); run(7, 1);
        cur_req = "R7"; do_load(5, 3); run(6, 1);
        cur_req = "R10"; set_gate(0); run(2, 1); set_gate(1); run(6, 1);

        cur_req = "R8"; do_load(6, 4); run(10, 1); do_load(7, 3); run(9, 1);

        cur_req = "R11"; do_load(2, 5); run(3, 1);
        repeat (6) @(negedge clk);

        cur_req = "R12"; set_gate(0);
        @(negedge clk);
        gate = 1'b1; tick = 1'b1; load_stb = 1'b1; load_mode = 3'd3; load_val = 16'd7;
        @(negedge clk);
        load_stb = 1'b0; tick = 1'b0;
        check(count_o == 16'd7, "R12", int'(count_o), 7);
        run(9, 1);

        cur_req = "R2"; do_load(0, 0);
        check(count_o == 16'd0 && out_o == 1'b0, "R2", int'(count_o), 0);
        run(1, 1);
        check(count_o == 16'd65535, "R2", int'(count_o), 65535);
        cur_req = "R7"; do_load(4, 0); run(65540, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule